// File: doc/BRIEF.md
# Synchronous Serial Transceiver

A byte-wide, full-duplex clocked serial engine. One shared buffer holds both the byte to send and the byte just received. With the start control high, each frame sends the buffer out on `sdo`, least-significant bit first. At the same time a frame is collected from `sdi`. At the end of each frame the received byte replaces the buffer contents and `irq` pulses for one cycle.

In internal-clock mode the block drives `sck_out` from a divided system clock. After every byte it holds the serial clock idle until software has read the received byte and then written the next one. In external-clock mode the block follows `sck_in`, which passes through a synchronizer, and never waits: if software misses its window, the old buffer contents go out again.

A transfer can end in two ways. Clearing `start` lets the current byte finish first. Raising `inhibit` aborts the transfer at once. Changing the mode empties the buffer.

Top module: `sync_serial_xcvr`

## Requirements
- R1: Transmit bits leave on `sdo` least-significant bit first. `sdo` changes only on a leading (falling) serial clock edge, so between frames it keeps the last bit sent.
- R2: `sdi` is sampled on the trailing (rising) serial clock edge. The first sample is bit 0 of the received byte. After FRAME_BITS samples, the byte appears on `rd_data` and `irq` is high for exactly one cycle.
- R3: In internal-clock mode `sck_out` idles high. Each half period of the serial clock lasts 2*(`div_sel`+2) system clocks, and each frame has exactly FRAME_BITS clock pulses.
- R4: In internal-clock mode, the next frame starts only after a pulse on `rd_en` followed by a pulse on `wr_en`. A write made while the received byte is still unread is ignored and leaves `rd_data` unchanged.
- R5: In external-clock mode (`ext_clk_mode`=1), frames follow `sck_in` back to back without waiting for software. If the buffer is not rewritten, the next frame sends the byte that was just received.
- R6: If `start` is cleared in the middle of a frame, that frame still completes, with its `irq` and its buffer update. After that `busy` is 0, and further serial clock pulses leave `rd_data`, `irq` and `sdo` unchanged.
- R7: While `inhibit` is high, the frame in progress is dropped from the next clock edge on: `sck_out` returns high, `busy` reads 0, no `irq` is raised, and the buffer is not updated.
- R8: A change of `ext_clk_mode` clears the buffer, so `rd_data` reads 0 from the next cycle on.
- R9: After reset, `sck_out`=1, `sdo`=1, `busy`=0, `irq`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_mode | input | 1 | 1: follow `sck_in`; 0: generate `sck_out` |
| start | input | 1 | Level: run transfers while high |
| inhibit | input | 1 | Level: abort and hold idle |
| div_sel | input | DIV_W | Internal half period is 2*(div_sel+2) clocks |
| wr_en | input | 1 | Write strobe for the shared buffer |
| wr_data | input | FRAME_BITS | Transmit byte |
| rd_en | input | 1 | Read-acknowledge strobe |
| rd_data | output | FRAME_BITS | Shared buffer contents |
| busy | output | 1 | Transfer active or armed |
| irq | output | 1 | One-cycle pulse per completed frame |
| sck_out | output | 1 | Generated serial clock |
| sck_in | input | 1 | External serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench uses the default parameters: 8-bit frames, a 2-bit divider select and a two-stage synchronizer. It runs `div_sel` at both 0 and 3, which covers the shortest and the longest internal half period. In internal mode `sdo` is looped back to `sdi`, so every transmitted byte must come back unchanged. The external clock is driven at a half period of five system clocks, just above the quarter-rate limit set by the synchronizer latency.

// File: rtl/sst_pkg.sv
package sst_pkg;
   // Serial clock edge events, one system-clock pulse each.
   typedef struct packed {
      logic lead;    // falling edge: drive next output bit
      logic trail;   // rising edge: sample input bit
   } sck_ev_t;
endpackage

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
   parameter int DIV_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic [DIV_W-1:0]    div_sel,
   output logic                sck_o,
   output sst_pkg::sck_ev_t    ev
);
   localparam int CNT_W = DIV_W + 2;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] half_m1;
   logic             wrap;

   // Half period 2*(div_sel+2) clocks, so the terminal count is 2*div_sel+3.
   assign half_m1 = {1'b0, div_sel, 1'b0} + CNT_W'(3);
   assign wrap    = run && (cnt_q == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck_o <= 1'b1;
      end else if (!run) begin
         cnt_q <= '0;
         sck_o <= 1'b1;
      end else if (wrap) begin
         cnt_q <= '0;
         sck_o <= ~sck_o;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ev.lead  = wrap &&  sck_o;
   assign ev.trail = wrap && !sck_o;

   // R3: the generated clock rests high whenever no frame is running
   assert_sck_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> sck_o);
endmodule

// File: rtl/sst_sync.sv
module sst_sync #(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_in,
   input  logic              sdi_in,
   output sst_pkg::sck_ev_t  ev,
   output logic              sdi_s
);
   logic [STAGES-1:0] sck_sh;
   logic [STAGES-1:0] sdi_sh;
   logic              sck_prev;

   if (STAGES < 2) begin : g_bad_stages
      $error("sst_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_sh[g] <= 1'b1;
               sdi_sh[g] <= 1'b0;
            end else begin
               sck_sh[g] <= sck_in;
               sdi_sh[g] <= sdi_in;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_sh[g] <= 1'b1;
               sdi_sh[g] <= 1'b0;
            end else begin
               sck_sh[g] <= sck_sh[g-1];
               sdi_sh[g] <= sdi_sh[g-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b1;
      else        sck_prev <= sck_sh[STAGES-1];
   end

   assign ev.lead  =  sck_prev & ~sck_sh[STAGES-1];
   assign ev.trail = ~sck_prev &  sck_sh[STAGES-1];
   assign sdi_s    =  sdi_sh[STAGES-1];
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter #(
   parameter int BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  sst_pkg::sck_ev_t  ev,
   input  logic              sdi_s,
   input  logic [BITS-1:0]   load_data,
   output logic              sdo,
   output logic [BITS-1:0]   rx_data,
   output logic              done
);
   localparam int CW = $clog2(BITS + 1);

   logic [BITS-1:0] tx_sh;
   logic [BITS-1:0] rx_sh;
   logic [CW-1:0]   bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh <= '0;
         rx_sh <= '0;
         bit_q <= '0;
         sdo   <= 1'b1;
      end else if (!active) begin
         bit_q <= '0;
      end else begin
         if (ev.lead) begin
            if (bit_q == '0) begin
               sdo   <= load_data[0];
               tx_sh <= load_data >> 1;
            end else begin
               sdo   <= tx_sh[0];
               tx_sh <= tx_sh >> 1;
            end
         end
         if (ev.trail) begin
            rx_sh <= {sdi_s, rx_sh[BITS-1:1]};
            bit_q <= (bit_q == CW'(BITS-1)) ? '0 : bit_q + 1'b1;
         end
      end
   end

   assign rx_data = {sdi_s, rx_sh[BITS-1:1]};
   assign done    = active && ev.trail && (bit_q == CW'(BITS-1));

   // R1: the output pin moves only on an accepted leading edge
   assert_sdo_only_on_lead_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(active && ev.lead) |=> $stable(sdo));
   // R2: the bit position never leaves the frame
   assert_bit_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_q < CW'(BITS));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
   parameter int FRAME_BITS  = 8,
   parameter int DIV_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ext_clk_mode,
   input  logic                  start,
   input  logic                  inhibit,
   input  logic [DIV_W-1:0]      div_sel,
   input  logic                  wr_en,
   input  logic [FRAME_BITS-1:0] wr_data,
   input  logic                  rd_en,
   output logic [FRAME_BITS-1:0] rd_data,
   output logic                  busy,
   output logic                  irq,
   output logic                  sck_out,
   input  logic                  sck_in,
   output logic                  sdo,
   input  logic                  sdi
);
   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("sync_serial_xcvr: FRAME_BITS must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("sync_serial_xcvr: DIV_W must be at least 1");
   end

   sst_pkg::sck_ev_t ev_int, ev_ext, ev_sel;
   logic                  sdi_s;
   logic                  mode_q, mode_chg;
   logic                  in_frame, need_read, tx_ready;
   logic [FRAME_BITS-1:0] buf_q, rx_word;
   logic                  frame_go, frame_live, done;

   assign mode_chg   = (mode_q != ext_clk_mode);
   assign frame_live = in_frame && !inhibit && !mode_chg;
   assign frame_go   = !in_frame && start && !inhibit && !mode_chg &&
                       (ext_clk_mode || (tx_ready && !need_read));

   sst_clkgen #(.DIV_W(DIV_W)) i_clkgen (
      .clk(clk), .rst_n(rst_n), .run(frame_live && !ext_clk_mode),
      .div_sel(div_sel), .sck_o(sck_out), .ev(ev_int));

   sst_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sdi_in(sdi),
      .ev(ev_ext), .sdi_s(sdi_s));

   assign ev_sel = ext_clk_mode ? ev_ext : ev_int;

   sst_shifter #(.BITS(FRAME_BITS)) i_shifter (
      .clk(clk), .rst_n(rst_n), .active(frame_live), .ev(ev_sel),
      .sdi_s(sdi_s), .load_data(buf_q), .sdo(sdo), .rx_data(rx_word),
      .done(done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= 1'b0;
         in_frame  <= 1'b0;
         need_read <= 1'b0;
         tx_ready  <= 1'b0;
         buf_q     <= '0;
         irq       <= 1'b0;
      end else begin
         mode_q <= ext_clk_mode;
         irq    <= done;

         if (inhibit || mode_chg || done) in_frame <= 1'b0;
         else if (frame_go)               in_frame <= 1'b1;

         if (mode_chg)                  buf_q <= '0;
         else if (done)                 buf_q <= rx_word;
         else if (wr_en && !need_read)  buf_q <= wr_data;

         if (mode_chg)    need_read <= 1'b0;
         else if (done)   need_read <= 1'b1;
         else if (rd_en)  need_read <= 1'b0;

         if (mode_chg || frame_go)     tx_ready <= 1'b0;
         else if (wr_en && !need_read) tx_ready <= 1'b1;
      end
   end

   assign rd_data = buf_q;
   assign busy    = in_frame || (start && !inhibit);

   // R2: one frame yields one single-cycle request
   assert_irq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R4: no internal frame runs while the received byte is unread
   assert_wait_for_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_clk_mode && need_read) |-> !in_frame);
   // R7: abort leaves the clock idle and raises no request
   assert_inhibit_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |=> (sck_out && !irq && !in_frame));
   // R8: a mode change empties the buffer
   assert_mode_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> (rd_data == '0));
endmodule

// File: tb/test_sync_serial_xcvr.sv
`timescale 1ns/1ps
module test_sync_serial_xcvr;
   localparam int FB = 8;
   localparam int DW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ext_clk_mode = 1'b0, start = 1'b0, inhibit = 1'b0;
   logic [DW-1:0] div_sel = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [FB-1:0] wr_data = '0;
   logic [FB-1:0] rd_data;
   logic          busy, irq, sck_out, sdo, sdi;
   logic          sck_in = 1'b1, tb_sdi = 1'b0, loop_en = 1'b0;

   int tests = 0, fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   assign sdi = loop_en ? sdo : tb_sdi;

   sync_serial_xcvr #(.FRAME_BITS(FB), .DIV_W(DW), .SYNC_STAGES(2)) i_sync_serial_xcvr (
      .clk(clk), .rst_n(rst_n), .ext_clk_mode(ext_clk_mode), .start(start),
      .inhibit(inhibit), .div_sel(div_sel), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .busy(busy), .irq(irq),
      .sck_out(sck_out), .sck_in(sck_in), .sdo(sdo), .sdi(sdi));

   // Monitor of the generated clock, sampled away from the active edge
   int            cyc = 0, fall_cnt = 0, rise_cnt = 0, irq_cnt = 0;
   int            last_fall = 0, period = 0;
   logic          sck_prev = 1'b1;
   logic [FB-1:0] cap = '0;
   always @(negedge clk) begin
      cyc++;
      if (irq) irq_cnt++;
      if (sck_prev && !sck_out) begin
         fall_cnt++;
         period    = cyc - last_fall;
         last_fall = cyc;
      end
      if (!sck_prev && sck_out) begin
         rise_cnt++;
         cap = {sdo, cap[FB-1:1]};
      end
      sck_prev = sck_out;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sw_write(input logic [FB-1:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic sw_read();
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic wait_irq(input string req, input int base);
      int n = 0;
      while (irq_cnt == base && n < 3000) begin @(negedge clk); n++; end
      chk(req, irq_cnt - base, 1);
   endtask

   // One external clock bit: falling edge with data, then rising edge
   task automatic ext_bit(input logic b, output logic seen);
      @(negedge clk); sck_in = 1'b0; tb_sdi = b;
      ticks(5);
      seen = sdo;
      sck_in = 1'b1;
      ticks(5);
   endtask

   task automatic t_reset();
      chk("R9 sck_out", sck_out, 1);
      chk("R9 sdo", sdo, 1);
      chk("R9 busy", busy, 0);
      chk("R9 irq", irq, 0);
      chk("R9 rd_data", rd_data, 0);
   endtask

   task automatic t_internal();
      int r0, i0;
      loop_en = 1'b1; div_sel = 2'd0;
      sw_write(8'hA5);
      r0 = rise_cnt; i0 = irq_cnt;
      @(negedge clk); start = 1'b1;
      ticks(3);
      chk("R6 busy during frame", busy, 1);
      wait_irq("R2 irq on frame end", i0);
      chk("R2 received byte", rd_data, 8'hA5);
      chk("R1 lsb-first output", cap, 8'hA5);
      chk("R3 pulses per frame", rise_cnt - r0, 8);
      chk("R3 period div 0", period, 8);
      ticks(1);
      chk("R2 irq single cycle", irq, 0);
      chk("R1 sdo holds last bit", sdo, 1);
   endtask

   task automatic t_autowait();
      int f0, i0;
      f0 = fall_cnt;
      ticks(30);
      chk("R4 clock held before read", fall_cnt - f0, 0);
      sw_write(8'h3C);
      chk("R4 early write ignored", rd_data, 8'hA5);
      sw_read();
      ticks(30);
      chk("R4 clock held before write", fall_cnt - f0, 0);
      div_sel = 2'd3;
      i0 = irq_cnt;
      sw_write(8'h3C);
      wait_irq("R4 resume after read and write", i0);
      chk("R4 second byte", rd_data, 8'h3C);
      chk("R3 period div 3", period, 20);
      chk("R1 second byte out", cap, 8'h3C);
      @(negedge clk); start = 1'b0;
      sw_read();
      loop_en = 1'b0;
   endtask

   task automatic t_external();
      logic [FB-1:0] pat, got;
      logic          s;
      int            i0;
      @(negedge clk); ext_clk_mode = 1'b1;
      ticks(3);
      sw_write(8'h81);
      @(negedge clk); start = 1'b1;
      ticks(4);
      i0 = irq_cnt; pat = 8'h4E;
      for (int i = 0; i < FB; i++) begin ext_bit(pat[i], s); got[i] = s; end
      chk("R5 first external irq", irq_cnt - i0, 1);
      chk("R5 external rx", rd_data, 8'h4E);
      chk("R1 external tx", got, 8'h81);
      ticks(6);
      i0 = irq_cnt; pat = 8'h17;
      for (int i = 0; i < FB; i++) begin ext_bit(pat[i], s); got[i] = s; end
      chk("R5 no wait irq", irq_cnt - i0, 1);
      chk("R5 resend of received byte", got, 8'h4E);
      chk("R5 second rx", rd_data, 8'h17);
      sw_read();
      sw_write(8'hC3);
      ticks(6);
      i0 = irq_cnt; pat = 8'h96;
      for (int i = 0; i < FB; i++) begin
         if (i == 3) start = 1'b0;
         ext_bit(pat[i], s); got[i] = s;
      end
      chk("R6 frame completes after stop", irq_cnt - i0, 1);
      chk("R6 whole byte stored", rd_data, 8'h96);
      chk("R6 tx after stop", got, 8'hC3);
      chk("R6 busy low after stop", busy, 0);
      i0 = irq_cnt; pat = 8'hFF;
      for (int i = 0; i < FB; i++) begin ext_bit(pat[i], s); got[i] = s; end
      chk("R6 no irq after stop", irq_cnt - i0, 0);
      chk("R6 buffer kept after stop", rd_data, 8'h96);
      chk("R6 sdo frozen after stop", got, 8'hFF);
   endtask

   task automatic t_inhibit();
      int f0, i0;
      @(negedge clk); ext_clk_mode = 1'b0;
      ticks(3);
      loop_en = 1'b1; div_sel = 2'd0;
      sw_write(8'h6B);
      f0 = fall_cnt; i0 = irq_cnt;
      @(negedge clk); start = 1'b1;
      while (fall_cnt - f0 < 3) @(negedge clk);
      ticks(1);
      inhibit = 1'b1;
      @(negedge clk);
      chk("R7 sck high on abort", sck_out, 1);
      chk("R7 busy low on abort", busy, 0);
      @(negedge clk); inhibit = 1'b0; start = 1'b0;
      f0 = fall_cnt;
      ticks(40);
      chk("R7 no irq after abort", irq_cnt - i0, 0);
      chk("R7 no clock after abort", fall_cnt - f0, 0);
      chk("R7 buffer untouched", rd_data, 8'h6B);
      loop_en = 1'b0;
   endtask

   task automatic t_mode();
      sw_write(8'h5A);
      chk("R8 buffer before change", rd_data, 8'h5A);
      @(negedge clk); ext_clk_mode = 1'b1;
      @(negedge clk);
      chk("R8 buffer cleared by mode change", rd_data, 0);
      @(negedge clk); ext_clk_mode = 1'b0;
   endtask

   initial begin
      ticks(3);
      rst_n = 1'b1;
      ticks(2);
      t_reset();
      t_internal();
      t_autowait();
      t_external();
      t_inhibit();
      t_mode();
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule